// File: doc/BRIEF.md
# Zero-Armed Run-of-Ones Detector

This block samples a serial bit `x` that is already synchronous to the clock. Its output `z` goes high when `x` has been 1 for four or more consecutive cycles. The run counts only after at least one 0 has been seen since reset. `z` is a Mealy output: it depends on the present state and on the present value of `x`, so it is high in the same cycle as the fourth 1.

The state is held in three encoded flops. There are five legal codes. Every unused code returns to the idle code in one clock, whatever the value of `x`.

For manufacturing test, a scan enable turns the three state flops into a shift register. Any code can then be loaded, and the current code can be read out one bit per clock. A synchronous reset wins over both scan and the functional logic.

Top module: `zarm_run_det`

## Requirements
- R1: When `rst` is high at a rising edge, the state becomes 000 after that edge, even when `scan_en` is high.
- R2: With `scan_en` low, `x`=0 in any legal state (000, 001, 011, 010, 110) moves the state to 001, and `z` is 0 in that cycle.
- R3: With `scan_en` low and `x`=1, the state steps 000→000, 001→011, 011→010 and 010→110, with `z`=0.
- R4: In state 110 with `x`=1, the state stays 110 and `z` is 1 in that same cycle. In every other case `z` is 0, so `z` = `x` AND (state == 110).
- R5: With `scan_en` low, the unused codes 100, 101 and 111 go to 000 for either value of `x`, with `z`=0.
- R6: With `scan_en` high and `rst` low, each clock shifts the bits in the order `scan_in`→`state[0]`→`state[1]`→`state[2]`. `scan_out` always equals `state[2]`. The functional next-state logic is ignored while shifting.
- R7: After reset, the sequence 0,1,1,1,1 on `x` makes `z` first go high while the fourth 1 is presented. `z` stays high while further 1s follow.
- R8: After reset with no 0 yet seen, any number of 1s leaves the state at 000 and `z` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| x | input | 1 | Serial data bit, already synchronous to `clk` |
| scan_en | input | 1 | High to shift the state register |
| scan_in | input | 1 | Serial input to the scan chain |
| z | output | 1 | Detect output (Mealy) |
| scan_out | output | 1 | Serial output of the scan chain (`state[2]`) |
| state | output | 3 | Present state code {y1,y2,y3} |

## Verification
Two functions can claim the same edge:
- reset against a scan shift;
- a scan shift against the functional transition that the present `x` would cause.

The bench drives `rst` and `scan_en` together with `scan_in`=1. It expects 000, and a stray 1 in `state[0]` would show that the shift leaked through. During every preload, `x` is held at 1, so a leaked functional step would land on a different code from the shifted one. Each of the eight codes is loaded this way and then stepped with both values of `x`. The code that follows is compared with the bench's own transition model.

// File: rtl/zrd_pkg.sv
package zrd_pkg;
  localparam int STATE_W = 3;
  typedef logic [STATE_W-1:0] code_t;

  localparam code_t C_IDLE = 3'b000;
  localparam code_t C_ZERO = 3'b001;
  localparam code_t C_ONE1 = 3'b011;
  localparam code_t C_ONE2 = 3'b010;
  localparam code_t C_RUN  = 3'b110;

  function automatic logic code_legal(input code_t c);
    return (c == C_IDLE) || (c == C_ZERO) || (c == C_ONE1) ||
           (c == C_ONE2) || (c == C_RUN);
  endfunction
endpackage

// File: rtl/zrd_next_state.sv
module zrd_next_state
  import zrd_pkg::*;
(
  input  code_t cur,
  input  logic  x,
  output code_t nxt
);
  always_comb begin
    nxt = C_IDLE;
    if (code_legal(cur)) begin
      if (!x) begin
        nxt = C_ZERO;
      end else begin
        unique case (cur)
          C_IDLE:  nxt = C_IDLE;
          C_ZERO:  nxt = C_ONE1;
          C_ONE1:  nxt = C_ONE2;
          C_ONE2:  nxt = C_RUN;
          C_RUN:   nxt = C_RUN;
          default: nxt = C_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/zrd_out_dec.sv
module zrd_out_dec
  import zrd_pkg::*;
(
  input  code_t cur,
  input  logic  x,
  output logic  hit
);
  assign hit = x & (cur == C_RUN);
endmodule

// File: rtl/zrd_scan_reg.sv
module zrd_scan_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift,
  input  logic         sin,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         sout
);
  localparam logic [W-1:0] RST_VAL = '0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic src;
      if (i == 0) begin : g_head
        assign src = sin;
      end else begin : g_link
        assign src = q[i-1];
      end
      always_ff @(posedge clk) begin
        if (rst)        q[i] <= RST_VAL[i];
        else if (shift) q[i] <= src;
        else            q[i] <= d[i];
      end
    end
  endgenerate

  assign sout = q[W-1];
endmodule

// File: rtl/zarm_run_det.sv
module zarm_run_det
  import zrd_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               x,
  input  logic               scan_en,
  input  logic               scan_in,
  output logic               z,
  output logic               scan_out,
  output logic [STATE_W-1:0] state
);
  code_t cur, nxt;

  zrd_next_state u_ns (.cur(cur), .x(x), .nxt(nxt));
  zrd_out_dec    u_od (.cur(cur), .x(x), .hit(z));

  zrd_scan_reg #(.W(STATE_W)) u_sr (
    .clk(clk), .rst(rst), .shift(scan_en), .sin(scan_in),
    .d(nxt), .q(cur), .sout(scan_out)
  );

  assign state = cur;
endmodule

// File: rtl/zarm_run_det_chk.sv
module zarm_run_det_chk
  import zrd_pkg::*;
(
  input logic         clk,
  input logic         rst,
  input logic         x,
  input logic         scan_en,
  input logic         scan_in,
  input logic         z,
  input logic         scan_out,
  input logic [2:0]   state
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> state == 3'b000);

  p_zero_to_001_r2: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !x && code_legal(state)) |=> state == 3'b001);

  p_run_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && x && state == 3'b110) |=> state == 3'b110);

  p_z_only_in_run_r4: assert property (@(posedge clk) disable iff (rst)
    z |-> (x && state == 3'b110));

  p_illegal_escape_r5: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && !code_legal(state)) |=> state == 3'b000);

  p_shift_order_r6: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> state == {$past(state[1:0]), $past(scan_in)});

  p_scan_tap_r6: assert property (@(posedge clk) disable iff (rst)
    scan_out == state[2]);
endmodule

bind zarm_run_det zarm_run_det_chk u_chk (
  .clk(clk), .rst(rst), .x(x), .scan_en(scan_en), .scan_in(scan_in),
  .z(z), .scan_out(scan_out), .state(state)
);

// File: tb/sim_zarm_run_det.sv
module sim_zarm_run_det;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x = 1'b0;
  logic scan_en = 1'b0;
  logic scan_in = 1'b0;
  logic z, scan_out;
  logic [2:0] state;

  int checks = 0;
  int errors = 0;
  logic [2:0] m = 3'b000;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    logic [2:0] st;
    logic       zz;
    logic       so;
  } item_t;
  item_t q[$];
  event chk_ev;

  always #4 clk = ~clk;

  zarm_run_det u0 (
    .clk(clk), .rst(rst), .x(x), .scan_en(scan_en), .scan_in(scan_in),
    .z(z), .scan_out(scan_out), .state(state)
  );

  function automatic logic m_legal(input logic [2:0] c);
    return c == 3'b000 || c == 3'b001 || c == 3'b011 || c == 3'b010 || c == 3'b110;
  endfunction

  function automatic logic [2:0] m_next(input logic [2:0] c, input logic xi);
    if (!m_legal(c)) return 3'b000;
    if (!xi) return 3'b001;
    case (c)
      3'b001:  return 3'b011;
      3'b011:  return 3'b010;
      3'b010:  return 3'b110;
      3'b110:  return 3'b110;
      default: return 3'b000;
    endcase
  endfunction

  function automatic string tag_for(input logic [2:0] c, input logic xi);
    if (!m_legal(c)) return "R5";
    if (!xi) return "R2";
    if (c == 3'b110) return "R4";
    return "R3";
  endfunction

  // Monitor: pops expected items and compares with the outputs.
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        checks++;
        if (state !== it.st || z !== it.zz || scan_out !== it.so) begin
          errors++;
          $display("FAIL %s: state=%b z=%b scan_out=%b expected state=%b z=%b scan_out=%b",
                   it.tag, state, z, scan_out, it.st, it.zz, it.so);
        end
      end
    end
  end

  // Driver: one clock cycle; check the present cycle, then advance the model.
  task automatic cyc(input string tag, input logic r, input logic xi,
                     input logic se, input logic si);
    item_t it;
    rst = r; x = xi; scan_en = se; scan_in = si;
    #1;
    it.tag = tag;
    it.st  = m;
    it.zz  = xi & (m == 3'b110);
    it.so  = m[2];
    q.push_back(it);
    -> chk_ev;
    #2;
    if (r)       m = 3'b000;
    else if (se) m = {m[1], m[0], si};
    else         m = m_next(m, xi);
    @(negedge clk);
  endtask

  task automatic preload(input logic [2:0] c);
    for (int b = 2; b >= 0; b--) cyc("R6", 1'b0, 1'b1, 1'b1, c[b]);
  endtask

  initial begin
    @(negedge clk);
    cyc("R1", 1'b1, 1'b0, 1'b0, 1'b0);
    // reset and scan in the same cycle: reset wins
    preload(3'b110);
    cyc("R1", 1'b1, 1'b1, 1'b1, 1'b1);
    cyc("R1", 1'b0, 1'b0, 1'b0, 1'b0);
    // R8: ones before any zero never arm
    cyc("R1", 1'b1, 1'b1, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) cyc("R8", 1'b0, 1'b1, 1'b0, 1'b0);
    // R7: zero then a run of ones
    cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 6; k++) cyc("R7", 1'b0, 1'b1, 1'b0, 1'b0);
    cyc("R7", 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 3; k++) cyc("R7", 1'b0, 1'b1, 1'b0, 1'b0);
    // Every code, both values of x
    for (int c = 0; c < 8; c++) begin
      for (int xv = 0; xv < 2; xv++) begin
        preload(3'(c));
        cyc(tag_for(3'(c), 1'(xv)), 1'b0, 1'(xv), 1'b0, 1'b0);
        cyc(tag_for(3'(c), 1'(xv)), 1'b0, 1'b0, 1'b0, 1'b0);
      end
    end
    // R6 readback: load 101 then shift it out
    preload(3'b101);
    for (int k = 0; k < 4; k++) cyc("R6", 1'b0, 1'b0, 1'b1, 1'b0);
    #2;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule